// File: doc/BRIEF.md
# Zone Protection Checker

This block sits next to a software-loaded translation buffer and makes the final access decision for an entry the buffer has already matched. Each request carries the matched entry's 4-bit zone number, the read/write/execute rights stored in that entry, the privilege mode of the access and the access kind. The block holds a 32-bit zone-protection register with sixteen 2-bit codes. It selects the code for the request's zone and uses it together with the privilege mode to choose one of three outcomes. The zone can grant everything, grant nothing, or defer to the entry's own rights with execute always added.

Requests enter on a valid/ready handshake and results leave on a second valid/ready handshake. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high when the single result slot is empty or is being emptied in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the result is held unchanged and no new request is taken. The zone-protection register is loaded through a plain write port.

Top module: `zone_prot_checker`

## Requirements
- R1: After reset, `rsp_valid` is 0, `req_ready` is 1 and every zone code is 0.
- R2: When `zp_wr_en` is high on a clock edge, `zp_wr_data` replaces the whole zone-protection register at that edge. Zone z uses bits [31-2z : 30-2z], so zone 0 is in the two most significant bits. A request accepted on the same edge sees the old register contents.
- R3: Zone code 3 grants rights 3'b111 and passes in either privilege mode. Rights are encoded with bit 0 = read, bit 1 = write and bit 2 = execute.
- R4: Zone code 2 with `req_user`=0 (supervisor) grants 3'b111 and passes. With `req_user`=1 it falls back to the entry rights.
- R5: Zone code 0 with `req_user`=1 gives rights 3'b000 and a deny result for every access kind. With `req_user`=0 it falls back to the entry rights.
- R6: Zone code 1 always falls back to the entry rights, in either mode.
- R7: On fallback, the result rights are `req_rights` with the execute bit forced to 1.
- R8: The result is checked in this order. If `req_kind[1]`=1 (fetch) the access needs execute. Otherwise, if `req_kind[0]`=1 (store) it needs write. Otherwise (load) it needs read. `rsp_result` is 2'b00 on pass and 2'b10 (the value -2) on deny.
- R9: A request accepted on edge n shows its result with `rsp_valid`=1 right after edge n. `rsp_valid` drops after an edge where `rsp_ready` is 1 and no new request is accepted.
- R10: While `rsp_valid`=1 and `rsp_ready`=0, `req_ready` is 0 and `rsp_rights` and `rsp_result` stay stable. When `rsp_ready` rises, a waiting request is accepted on the same edge that drains the old result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| zp_wr_en | input | 1 | Zone-protection register write strobe |
| zp_wr_data | input | 32 | New zone-protection register value |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_zone | input | 4 | Zone number of the matched entry |
| req_rights | input | 3 | Entry rights {exec, write, read} |
| req_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| req_kind | input | 2 | 0 load, 1 store, 2 or 3 fetch |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result consumer ready |
| rsp_rights | output | 3 | Final rights {exec, write, read} |
| rsp_result | output | 2 | 2'b00 pass, 2'b10 deny |

## Verification
The bench covers each code/mode pair, including the inversion where zone code 0 blocks user accesses but defers for supervisor accesses. A design that swapped those cases would grant user accesses that should be blocked. It runs fallback fetches with an empty entry, which must pass because execute is forced on. A design that skipped the forcing would deny them. It sends stores that hold read but lack write, and fetches with kind 3, which catch a reordered or partial access-kind decode. It also checks the zone field order, the old-value use on a simultaneous write, and result holding under back-pressure. A reversed field order, an early write-through or a result overwritten while stalled would each show as wrong rights at the ports.

// File: rtl/zpc_pkg.sv
package zpc_pkg;
  localparam int RIGHTS_W = 3;
  localparam int RES_W    = 2;
  localparam int BIT_RD   = 0;
  localparam int BIT_WR   = 1;
  localparam int BIT_EX   = 2;
  localparam logic [RES_W-1:0] RES_PASS = 2'b00;
  localparam logic [RES_W-1:0] RES_DENY = 2'b10;

  typedef enum logic [1:0] {
    ZC_BLOCK_USER = 2'd0,
    ZC_ENTRY      = 2'd1,
    ZC_OPEN_SUP   = 2'd2,
    ZC_OPEN_ALL   = 2'd3
  } zone_code_e;

  typedef struct packed {
    logic [RIGHTS_W-1:0] rights;
    logic [RES_W-1:0]    result;
  } verdict_t;

  // True when the zone code defers to the entry's stored rights.
  function automatic logic uses_entry(input logic [1:0] code, input logic user);
    case (zone_code_e'(code))
      ZC_OPEN_ALL:   uses_entry = 1'b0;
      ZC_OPEN_SUP:   uses_entry = user;
      ZC_BLOCK_USER: uses_entry = !user;
      default:       uses_entry = 1'b1;
    endcase
  endfunction

  // Bit of the rights vector an access kind needs (fetch > store > load).
  function automatic int needed_bit(input logic [1:0] kind);
    if (kind[1])      needed_bit = BIT_EX;
    else if (kind[0]) needed_bit = BIT_WR;
    else              needed_bit = BIT_RD;
  endfunction
endpackage

// File: rtl/zpc_zone_reg.sv
module zpc_zone_reg #(
  parameter int ZONE_BITS = 4,
  parameter int CODE_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [(CODE_W<<ZONE_BITS)-1:0] wr_data,
  input  logic [ZONE_BITS-1:0] zone,
  output logic [CODE_W-1:0]    code
);
  localparam int NUM_ZONES = 1 << ZONE_BITS;
  localparam int REG_W     = CODE_W * NUM_ZONES;

  logic [REG_W-1:0]  zp_q;
  logic [CODE_W-1:0] codes [NUM_ZONES];

  always_ff @(posedge clk) begin
    if (!rst_n)     zp_q <= '0;
    else if (wr_en) zp_q <= wr_data;
  end

  // Zone 0 occupies the most significant field.
  for (genvar z = 0; z < NUM_ZONES; z++) begin : g_field
    assign codes[z] = zp_q[REG_W-1-z*CODE_W -: CODE_W];
  end

  assign code = codes[zone];

  assert_write_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> zp_q == $past(wr_data));
endmodule

// File: rtl/zpc_decide.sv
module zpc_decide
  import zpc_pkg::*;
(
  input  logic [1:0]          code,
  input  logic                user,
  input  logic [1:0]          kind,
  input  logic [RIGHTS_W-1:0] entry_rights,
  output verdict_t            verdict
);
  logic [RIGHTS_W-1:0] rights;
  logic                fallback;

  always_comb begin
    fallback = uses_entry(code, user);
    if (fallback) begin
      rights         = entry_rights;
      rights[BIT_EX] = 1'b1;
    end else if (zone_code_e'(code) == ZC_BLOCK_USER) begin
      rights = '0;
    end else begin
      rights = '1;
    end
    verdict.rights = rights;
    verdict.result = rights[needed_bit(kind)] ? RES_PASS : RES_DENY;
  end
endmodule

// File: rtl/zpc_out_stage.sv
module zpc_out_stage
  import zpc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  output logic     in_ready,
  input  verdict_t in_data,
  output logic     out_valid,
  input  logic     out_ready,
  output verdict_t out_data
);
  logic fire;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_hold_stalled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data));
  assert_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);
  assert_no_accept_stalled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: rtl/zone_prot_checker.sv
module zone_prot_checker
  import zpc_pkg::*;
#(
  parameter int ZONE_BITS = 4,
  parameter int CODE_W    = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                zp_wr_en,
  input  logic [(CODE_W<<ZONE_BITS)-1:0]      zp_wr_data,
  input  logic                                req_valid,
  output logic                                req_ready,
  input  logic [ZONE_BITS-1:0]                req_zone,
  input  logic [RIGHTS_W-1:0]                 req_rights,
  input  logic                                req_user,
  input  logic [1:0]                          req_kind,
  output logic                                rsp_valid,
  input  logic                                rsp_ready,
  output logic [RIGHTS_W-1:0]                 rsp_rights,
  output logic [RES_W-1:0]                    rsp_result
);
  logic [CODE_W-1:0] zcode;
  verdict_t          verdict_d;
  verdict_t          verdict_q;
  logic              fire;

  zpc_zone_reg #(.ZONE_BITS(ZONE_BITS), .CODE_W(CODE_W)) u_zone_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (zp_wr_en),
    .wr_data (zp_wr_data),
    .zone    (req_zone),
    .code    (zcode)
  );

  zpc_decide u_decide (
    .code         (zcode[1:0]),
    .user         (req_user),
    .kind         (req_kind),
    .entry_rights (req_rights),
    .verdict      (verdict_d)
  );

  zpc_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (verdict_d),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_data  (verdict_q)
  );

  assign rsp_rights = verdict_q.rights;
  assign rsp_result = verdict_q.result;
  assign fire       = req_valid && req_ready;

  assert_open_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && zcode == 2'd3) |=> rsp_rights == 3'b111 && rsp_result == RES_PASS);
  assert_open_sup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && zcode == 2'd2 && !req_user) |=> rsp_rights == 3'b111 && rsp_result == RES_PASS);
  assert_block_user_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && zcode == 2'd0 && req_user) |=> rsp_rights == 3'b000 && rsp_result == RES_DENY);
  assert_entry_exec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (zcode == 2'd1 || (zcode == 2'd2 && req_user) || (zcode == 2'd0 && !req_user)))
      |=> rsp_rights == ($past(req_rights) | 3'b100));
  assert_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ((rsp_result == RES_PASS) ==
              ($past(req_kind[1]) ? rsp_rights[2] :
               $past(req_kind[0]) ? rsp_rights[1] : rsp_rights[0])));
endmodule

// File: tb/test_zone_prot_checker.sv
module test_zone_prot_checker;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        zp_wr_en;
  logic [31:0] zp_wr_data;
  logic        req_valid;
  logic        req_ready;
  logic [3:0]  req_zone;
  logic [2:0]  req_rights;
  logic        req_user;
  logic [1:0]  req_kind;
  logic        rsp_valid;
  logic        rsp_ready;
  logic [2:0]  rsp_rights;
  logic [1:0]  rsp_result;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(PERIOD/2) clk = ~clk;

  zone_prot_checker i_zone_prot_checker (
    .clk(clk), .rst_n(rst_n), .zp_wr_en(zp_wr_en), .zp_wr_data(zp_wr_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_zone(req_zone),
    .req_rights(req_rights), .req_user(req_user), .req_kind(req_kind),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rights(rsp_rights),
    .rsp_result(rsp_result));

  // {zone, user, kind, entry, exp_rights, exp_deny}; zone z code = z mod 4
  localparam int NV = 16;
  localparam logic [13:0] VEC [NV] = '{
    {4'd3,  1'b1, 2'd1, 3'b000, 3'b111, 1'b0},  // R3
    {4'd7,  1'b0, 2'd2, 3'b000, 3'b111, 1'b0},  // R3
    {4'd2,  1'b0, 2'd1, 3'b000, 3'b111, 1'b0},  // R4
    {4'd2,  1'b1, 2'd1, 3'b001, 3'b101, 1'b1},  // R4 R8
    {4'd6,  1'b1, 2'd0, 3'b001, 3'b101, 1'b0},  // R4
    {4'd0,  1'b1, 2'd0, 3'b111, 3'b000, 1'b1},  // R5
    {4'd4,  1'b1, 2'd2, 3'b111, 3'b000, 1'b1},  // R5
    {4'd0,  1'b0, 2'd1, 3'b010, 3'b110, 1'b0},  // R5
    {4'd4,  1'b0, 2'd0, 3'b010, 3'b110, 1'b1},  // R5 R8
    {4'd1,  1'b0, 2'd2, 3'b000, 3'b100, 1'b0},  // R6 R7
    {4'd5,  1'b1, 2'd1, 3'b011, 3'b111, 1'b0},  // R6
    {4'd9,  1'b1, 2'd0, 3'b000, 3'b100, 1'b1},  // R6 R8
    {4'd13, 1'b1, 2'd3, 3'b000, 3'b100, 1'b0},  // R8
    {4'd15, 1'b1, 2'd0, 3'b000, 3'b111, 1'b0},  // R3
    {4'd10, 1'b1, 2'd3, 3'b010, 3'b110, 1'b0},  // R7
    {4'd14, 1'b0, 2'd0, 3'b000, 3'b111, 1'b0}   // R4
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put(input logic [3:0] z, input logic u, input logic [1:0] k,
                     input logic [2:0] r);
    req_zone = z; req_user = u; req_kind = k; req_rights = r; req_valid = 1'b1;
  endtask

  // Issue one request, wait for acceptance edge, sample after it.
  task automatic run_one(input string req, input logic [3:0] z, input logic u,
                         input logic [1:0] k, input logic [2:0] r,
                         input logic [2:0] er, input logic ed);
    @(negedge clk);
    put(z, u, k, r);
    @(negedge clk);
    req_valid = 1'b0;
    chk({req, " valid"}, {7'd0, rsp_valid}, 8'd1);
    chk({req, " rights"}, {5'd0, rsp_rights}, {5'd0, er});
    chk({req, " result"}, {6'd0, rsp_result}, ed ? 8'h02 : 8'h00);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; zp_wr_en = 0; zp_wr_data = '0; req_valid = 0; rsp_ready = 1;
    req_zone = '0; req_rights = '0; req_user = 0; req_kind = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid", {7'd0, rsp_valid}, 8'd0);
    chk("R1 req_ready", {7'd0, req_ready}, 8'd1);
    run_one("R1 zones zero", 4'd3, 1'b1, 2'd0, 3'b111, 3'b000, 1'b1);

    // R2: write and request on the same edge use the old codes
    @(negedge clk);
    zp_wr_en = 1; zp_wr_data = 32'h1B1B1B1B;
    put(4'd3, 1'b1, 2'd0, 3'b000);
    @(negedge clk);
    zp_wr_en = 0; req_valid = 0;
    chk("R2 old value rights", {5'd0, rsp_rights}, 8'd0);
    chk("R2 old value result", {6'd0, rsp_result}, 8'h02);
    run_one("R2 new value", 4'd3, 1'b1, 2'd0, 3'b000, 3'b111, 1'b0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [13:0] v;
      v = VEC[i];
      run_one($sformatf("R3-R8 vec%0d", i), v[13:10], v[9], v[8:7], v[6:4], v[3:1], v[0]);
    end

    // R9: rsp_valid drops one edge later with no new request
    @(negedge clk);
    chk("R9 drop", {7'd0, rsp_valid}, 8'd0);

    // R2 field position: only zone 0 open
    @(negedge clk);
    zp_wr_en = 1; zp_wr_data = 32'hC0000000;
    @(negedge clk);
    zp_wr_en = 0;
    run_one("R2 zone0 msb", 4'd0, 1'b1, 2'd1, 3'b000, 3'b111, 1'b0);
    run_one("R2 zone15 lsb", 4'd15, 1'b1, 2'd0, 3'b111, 3'b000, 1'b1);
    @(negedge clk);
    zp_wr_en = 1; zp_wr_data = 32'h00000003;
    @(negedge clk);
    zp_wr_en = 0;
    run_one("R2 zone15 open", 4'd15, 1'b1, 2'd1, 3'b000, 3'b111, 1'b0);

    // R10 back-pressure
    @(negedge clk);
    rsp_ready = 0;
    put(4'd15, 1'b1, 2'd0, 3'b000);          // A: 111 pass
    @(negedge clk);
    put(4'd0, 1'b1, 2'd0, 3'b111);           // B: 000 deny
    for (int c = 0; c < 3; c++) begin
      chk("R10 stalled valid", {7'd0, rsp_valid}, 8'd1);
      chk("R10 stalled ready", {7'd0, req_ready}, 8'd0);
      chk("R10 held rights", {5'd0, rsp_rights}, 8'h07);
      chk("R10 held result", {6'd0, rsp_result}, 8'h00);
      @(negedge clk);
    end
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R10 next valid", {7'd0, rsp_valid}, 8'd1);
    chk("R10 next rights", {5'd0, rsp_rights}, 8'h00);
    chk("R10 next result", {6'd0, rsp_result}, 8'h02);
    @(negedge clk);
    chk("R9 drained", {7'd0, rsp_valid}, 8'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule